// File: doc/BRIEF.md
# Framed Serial Sample Receiver

This block collects one 32-bit input word per channel sample from a serial data line and passes the word to the channel datapath. It makes its own serial bit clock by dividing the master clock by a programmable 5-bit ratio. It also times the frames itself. A frame begins once every `frame_len` master cycles, where `frame_len` is the product of the interpolation factors of the channel's stages, so the frame rate matches the channel's input sample rate.

At the start of each frame the block raises a frame strobe for one serial bit period. It then shifts in 32 bits, most significant first. After the last bit it presents the assembled word with a one-cycle valid pulse. Serial clock edges after the 32nd bit of a frame are ignored. The divider restarts at every frame start, so every frame has the same bit timing. Bit timing is also regular across frames when the frame period is a whole multiple of the bit period. `div_sel` and `frame_len` are expected to stay constant while the block is out of reset.

Top module: `serial_frame_rx`

## Requirements
- R1: A serial bit period lasts `div_sel`+1 master cycles. Bit-period phase 0 is the master cycle in which a frame starts or the previous period ends. `sclk_o` is high in phases 0 through floor(`div_sel`/2) and low in the later phases. With `div_sel` = 0, `sclk_o` stays high.
- R2: A frame starts in the first master cycle after reset and then every `frame_len` master cycles. `fstrobe_o` is high during the first bit period of each frame and low at all other times.
- R3: Each bit is sampled from `sdata_i` in the last master cycle of its bit period, which is the cycle ending at the rising edge of `sclk_o`. Bit k of a frame (counting from 0) lands in `word_o[31-k]`, so the first bit received is the MSB.
- R4: `word_vld_o` is high for exactly one master cycle: the cycle that follows the sampling of the 32nd bit. `word_o` carries the new word in that cycle and keeps it until the next valid pulse.
- R5: Bit periods that fall after the 32nd bit of a frame are ignored. They produce no pulse and leave `word_o` unchanged.
- R6: A frame whose `frame_len` ends before 32 bits have been sampled produces no valid pulse. The partial bits are dropped, and the next frame starts again from bit 0.
- R7: A synchronous reset clears the frame, divider and bit counters. While reset is asserted, `word_vld_o` is 0 and `word_o` is 0.
- R8: The divider restarts at every frame start. When `frame_len` is not a multiple of `div_sel`+1, the bit timing within each frame is still the same as in the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 5 | Serial clock divider; bit period is div_sel+1 cycles |
| frame_len | input | 16 | Total channel interpolation; frame period in master cycles |
| sdata_i | input | 1 | Serial data line |
| sclk_o | output | 1 | Generated serial bit clock |
| fstrobe_o | output | 1 | Frame-start strobe, one bit period wide |
| word_o | output | 32 | Last assembled word |
| word_vld_o | output | 1 | One-cycle pulse marking a new word |

## Verification
The bench runs a table of divider and frame-length pairs. An exact fit of 32 bits per frame at divider 0 and at divider 31 shows that the valid pulse and the next frame strobe can fall in the same cycle. Frames with spare time, in which the line is driven high, separate a receiver that ignores surplus bits from one that keeps shifting. A frame too short for 32 bits shows that partial words are discarded. A frame length that is not a multiple of the bit period shows that the divider restarts at each frame. Alternating words with distinct patterns in consecutive frames expose MSB/LSB swaps and stale data. A reset in the middle of a frame checks that all counters restart.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 5,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              fstrobe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [LEN_W-1:0]  scnt_q;
  logic [DIV_W-1:0]  dcnt_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [WORD_W-1:0] shreg_q;

  logic              ftick, btick, take, last;
  logic [DIV_W-1:0]  ph;
  logic [CNT_W-1:0]  bc;
  logic [WORD_W-1:0] shnext;

  assign ftick     = (scnt_q == '0);
  assign ph        = ftick ? '0 : dcnt_q;
  assign bc        = ftick ? '0 : bcnt_q;
  assign btick     = (ph == div_sel);
  assign take      = btick && (bc < CNT_W'(WORD_W));
  assign last      = take && (bc == CNT_W'(WORD_W - 1));
  assign shnext    = {shreg_q[WORD_W-2:0], sdata_i};
  assign sclk_o    = (ph <= (div_sel >> 1));
  assign fstrobe_o = (bc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt_q     <= '0;
      dcnt_q     <= '0;
      bcnt_q     <= '0;
      shreg_q    <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      scnt_q     <= (scnt_q == frame_len - LEN_W'(1)) ? '0 : scnt_q + LEN_W'(1);
      dcnt_q     <= btick ? '0 : ph + DIV_W'(1);
      bcnt_q     <= take ? bc + CNT_W'(1) : bc;
      word_vld_o <= last;
      if (take) shreg_q <= shnext;
      if (last) word_o  <= shnext;
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  div_sel,
  input logic        sclk_o,
  input logic        fstrobe_o,
  input logic [31:0] word_o,
  input logic        word_vld_o
);
  assert_sclk_div0_R1: assert property (@(posedge clk) disable iff (rst)
    (div_sel == 5'd0) |-> sclk_o);

  assert_strobe_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fstrobe_o);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !word_vld_o |-> $stable(word_o));

  assert_no_strobe_before_vld_R3: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> !$past(fstrobe_o));
endmodule

bind serial_frame_rx serial_frame_rx_chk chk_i (
  .clk(clk), .rst(rst), .div_sel(div_sel), .sclk_o(sclk_o),
  .fstrobe_o(fstrobe_o), .word_o(word_o), .word_vld_o(word_vld_o)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  div_sel = '0;
  logic [15:0] frame_len = 16'd32;
  logic        sdata_i = 1'b0;
  logic        sclk_o, fstrobe_o, word_vld_o;
  logic [31:0] word_o;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  serial_frame_rx dut_i (
    .clk(clk), .rst(rst), .div_sel(div_sel), .frame_len(frame_len),
    .sdata_i(sdata_i), .sclk_o(sclk_o), .fstrobe_o(fstrobe_o),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  localparam int NV = 7;
  localparam int          V_DIV [NV] = '{0, 0, 3, 31, 1, 2, 3};
  localparam int          V_LEN [NV] = '{32, 40, 160, 1024, 70, 50, 150};
  localparam logic [31:0] V_W0  [NV] = '{32'h8000_0001, 32'hA5A5_0F0F, 32'h1234_5678,
                                         32'hFFFF_0000, 32'hC001_D00D, 32'hFFFF_FFFF, 32'h0F1E_2D3C};
  localparam logic [31:0] V_W1  [NV] = '{32'h7FFF_FFFE, 32'h5A5A_F0F0, 32'hEDCB_A987,
                                         32'h0000_FFFF, 32'h3FFE_2FF2, 32'hFFFF_FFFF, 32'hF0E1_D2C3};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run_case(input int d, input int len, input logic [31:0] w0,
                          input logic [31:0] w1, input int ncyc);
    logic [31:0] held;
    held = '0;
    @(negedge clk);
    div_sel = 5'(d);
    frame_len = 16'(len);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 vld in reset", {31'd0, word_vld_o}, 32'd0);
    chk("R7 word in reset", word_o, 32'd0);
    for (int c = 0; c < ncyc; c++) begin
      int p, idx, ph;
      logic [31:0] w;
      logic ev;
      rst = 1'b0;
      p   = c % len;
      idx = p / (d + 1);
      ph  = p % (d + 1);
      w   = ((c / len) % 2 == 0) ? w0 : w1;
      sdata_i = (idx < 32) ? w[31 - idx] : 1'b1;
      chk("R2/R8 fstrobe", {31'd0, fstrobe_o}, {31'd0, (idx == 0)});
      chk("R1 sclk", {31'd0, sclk_o}, {31'd0, (ph <= d / 2)});
      ev = (idx == 31) && (ph == d);
      @(negedge clk);
      chk("R4/R6 valid", {31'd0, word_vld_o}, {31'd0, ev});
      if (ev) held = w;
      chk("R3/R5 word", word_o, held);
    end
  endtask

  initial begin
    for (int v = 0; v < NV; v++)
      run_case(V_DIV[v], V_LEN[v], V_W0[v], V_W1[v], 3 * V_LEN[v]);

    run_case(1, 80, 32'hDEAD_BEEF, 32'h0123_4567, 30);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R7 vld after mid reset", {31'd0, word_vld_o}, 32'd0);
    chk("R7 word after mid reset", word_o, 32'd0);
    chk("R7 strobe pending", {31'd0, fstrobe_o}, 32'd1);
    run_case(1, 80, 32'hDEAD_BEEF, 32'h0123_4567, 240);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule